// File: doc/BRIEF.md
# Single-Counter Event Performance Monitor

This block counts one kind of pipeline event at a time in a single counter register, which keeps its area small. Software chooses the event with a 4-bit event identifier. It then clears, starts and stops the counter with a 2-bit command, and it reads the count from the output at any time. To profile several event types, the program is run once for each selection.

The pipeline drives one-cycle event pulses for the following events: retired instructions, load-use stalls, loads, stores, jumps, branches and delay-slot nops. Clock cycles need no input, because every cycle counts while the cycle event is selected. The running flag and the selected identifier are held in registers. Counting therefore starts on the cycle after a start command, and stops on the cycle after a stop command.

Top module: `perf_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0, the counter becomes idle and the selection becomes 0.
- R2: The command encoding on `op_i` is: 2'b00 does nothing, 2'b01 clears the count, 2'b10 starts counting and latches `sel_id_i`, and 2'b11 stops counting. A start takes effect for events in the cycle that follows the start cycle.
- R3: While the counter is running, the count rises by exactly one in each cycle in which the selected event is high. In every other cycle the count is unchanged.
- R4: A clear makes the count 0 at the next edge, even when a counted event occurs in the same cycle. A clear does not change the running state or the selection.
- R5: After a stop, the count holds its value until a clear. A later start continues from the held value.
- R6: Event ID 0 counts every cycle in which the counter runs.
- R7: ID 1 counts `ev_i[0]` (instructions) and ID 2 counts `ev_i[1]` (load-use stalls). IDs 7 to 11 count `ev_i[2]` to `ev_i[6]`, in this order: loads, stores, jumps, branches, delay-slot nops.
- R8: IDs 3 to 6 and 12 to 15 are reserved. While one of them is selected, the count holds.
- R9: The count wraps from its all-ones value to 0 without any indication.
- R10: A start issued while the counter is running switches to the new event and does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Command: none, clear, start, stop |
| sel_id_i | input | 4 | Event identifier, latched when a start command is given |
| ev_i | input | 7 | One-cycle event pulses from the pipeline |
| count_o | output | CNT_W | Current count, used for readback |

## Verification
The bench checks the case where a clear and a selected event occur in the same cycle. A design that gives the event priority would read 1 after that clear instead of 0. It checks the one-cycle latency of start and stop: a monitor that counted from the start cycle itself would be off by one on every run. It selects reserved IDs with all events high, which catches a decoder that masks only the low bits of the identifier. It also drives the counter past its all-ones value to confirm the wrap. Random command and event traffic then exercises re-selection while running, to show that a running start never clears the count.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int ID_W   = 4;
    localparam int NUM_EV = 7;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CLEAR = 2'b01,
        OP_START = 2'b10,
        OP_STOP  = 2'b11
    } pm_op_e;

    typedef struct packed {
        logic            run;
        logic [ID_W-1:0] sel;
    } pm_cfg_t;

    // Bit of the event vector used by each event identifier
    localparam int EVB_INSTR  = 0;
    localparam int EVB_LDSTL  = 1;
    localparam int EVB_LOAD   = 2;
    localparam int EVB_STORE  = 3;
    localparam int EVB_JUMP   = 4;
    localparam int EVB_BRANCH = 5;
    localparam int EVB_DNOP   = 6;

    function automatic logic id_known(input logic [ID_W-1:0] id);
        return (id <= 4'd2) || (id >= 4'd7 && id <= 4'd11);
    endfunction

    function automatic logic ev_hit(input logic [ID_W-1:0] id,
                                    input logic [NUM_EV-1:0] ev);
        logic h;
        case (id)
            4'd0:    h = 1'b1;
            4'd1:    h = ev[EVB_INSTR];
            4'd2:    h = ev[EVB_LDSTL];
            4'd7:    h = ev[EVB_LOAD];
            4'd8:    h = ev[EVB_STORE];
            4'd9:    h = ev[EVB_JUMP];
            4'd10:   h = ev[EVB_BRANCH];
            4'd11:   h = ev[EVB_DNOP];
            default: h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import perfmon_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pm_op_e          op,
    input  logic [ID_W-1:0] sel_id,
    output pm_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            case (op)
                OP_START: begin
                    cfg.run <= 1'b1;
                    cfg.sel <= sel_id;
                end
                OP_STOP:  cfg.run <= 1'b0;
                default:  ;
            endcase
        end
    end

    p_start_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_START) |=> (cfg.run && cfg.sel == $past(sel_id)));

    p_stop_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STOP) |=> !cfg.run);

    p_clear_keeps_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> $stable(cfg));

endmodule

// File: rtl/pm_evsel.sv
module pm_evsel
    import perfmon_pkg::*;
(
    input  pm_cfg_t           cfg,
    input  logic [NUM_EV-1:0] ev,
    output logic              inc
);

    logic hit;

    always_comb begin
        hit = ev_hit(cfg.sel, ev);
        inc = cfg.run & hit;
    end

    always_comb begin
        if (!id_known(cfg.sel)) begin
            a_reserved_quiet_r8: assert (!inc);
        end
    end

endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + STEP;
    end

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + STEP));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import perfmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic [3:0]       sel_id_i,
    input  logic [6:0]       ev_i,
    output logic [CNT_W-1:0] count_o
);

    pm_op_e  op;
    pm_cfg_t cfg;
    logic    inc;
    logic    clr;

    assign op  = pm_op_e'(op_i);
    assign clr = (op == OP_CLEAR);

    pm_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .sel_id (sel_id_i),
        .cfg    (cfg)
    );

    pm_evsel u_evsel (
        .cfg (cfg),
        .ev  (ev_i),
        .inc (inc)
    );

    pm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .inc (inc),
        .cnt (count_o)
    );

    p_cycle_count_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && cfg.sel == 4'd0 && !clr) |=> (count_o == $past(count_o) + CNT_W'(1)));

    p_reserved_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!id_known(cfg.sel) && !clr) |=> $stable(count_o));

endmodule

// File: tb/tb_perf_monitor.sv
module tb_perf_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    op_i = 2'b00;
    logic [3:0]    sel_id_i = 4'd0;
    logic [6:0]    ev_i = '0;
    logic [CW-1:0] count_o;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    logic          m_run = 1'b0;
    logic [3:0]    m_sel = 4'd0;
    logic [CW-1:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_monitor #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .op_i(op_i), .sel_id_i(sel_id_i),
        .ev_i(ev_i), .count_o(count_o)
    );

    function automatic logic ref_hit(input logic [3:0] id, input logic [6:0] ev);
        case (id)
            4'd0:  return 1'b1;
            4'd1:  return ev[0];
            4'd2:  return ev[1];
            4'd7:  return ev[2];
            4'd8:  return ev[3];
            4'd9:  return ev[4];
            4'd10: return ev[5];
            4'd11: return ev[6];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] exp);
        n_vec++;
        if (count_o !== exp) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d at %0t", tag, count_o, exp, $time);
        end
    endtask

    // drive one cycle, update reference, compare after the edge
    task automatic step(input logic [1:0] op, input logic [3:0] id,
                        input logic [6:0] ev, input string tag);
        logic          n_run;
        logic [3:0]    n_sel;
        logic [CW-1:0] n_cnt;
        op_i = op; sel_id_i = id; ev_i = ev;
        n_run = m_run; n_sel = m_sel; n_cnt = m_cnt;
        if (op == 2'b01) n_cnt = '0;
        else if (m_run && ref_hit(m_sel, ev)) n_cnt = m_cnt + 1'b1;
        if (op == 2'b10) begin n_run = 1'b1; n_sel = id; end
        if (op == 2'b11) n_run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_run = n_run; m_sel = n_sel; m_cnt = n_cnt;
        check(tag, m_cnt);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset count", '0);

        // R1: idle after reset, events ignored
        step(2'b00, 4'd0, 7'h7f, "R1 idle ignores events");
        check("R1 idle hold", 8'd0);

        // R2/R7: start on instructions; start cycle itself not counted
        step(2'b10, 4'd1, 7'h01, "R2 start cycle not counted");
        check("R2 latency", 8'd0);
        step(2'b00, 4'd0, 7'h01, "R7 instr counted");
        check("R7 id1", 8'd1);
        step(2'b00, 4'd0, 7'h7e, "R3 other events ignored");
        check("R3 unselected", 8'd1);

        // R4: clear with simultaneous event
        step(2'b01, 4'd0, 7'h01, "R4 clear beats event");
        check("R4 clear", 8'd0);
        step(2'b00, 4'd0, 7'h01, "R4 still running after clear");
        check("R4 run kept", 8'd1);

        // R5: stop holds, restart continues
        step(2'b11, 4'd0, 7'h01, "R5 stop cycle still counts");
        check("R5 stop latency", 8'd2);
        step(2'b00, 4'd0, 7'h7f, "R5 held");
        step(2'b00, 4'd0, 7'h7f, "R5 held");
        check("R5 hold", 8'd2);
        step(2'b10, 4'd9, 7'h00, "R5 restart");
        step(2'b00, 4'd0, 7'h10, "R7 jump counted");
        check("R5 continue", 8'd3);

        // R10: reselect while running
        step(2'b10, 4'd2, 7'h10, "R10 reselect cycle uses old id");
        check("R10 old id", 8'd4);
        step(2'b00, 4'd0, 7'h10, "R10 new id ignores jump");
        step(2'b00, 4'd0, 7'h02, "R10 new id stall");
        check("R10 switched", 8'd5);

        // R7: every mapped id against a one-hot event
        for (int b = 2; b < 7; b++) begin
            step(2'b01, 4'd0, 7'h00, "R4 clear");
            step(2'b10, 4'(b + 5), 7'h00, "R7 select");
            step(2'b00, 4'd0, 7'(1 << b), "R7 mapped bit");
            step(2'b00, 4'd0, ~7'(1 << b), "R7 other bits");
            check("R7 mapping", 8'd1);
        end

        // R8: reserved ids hold with all events high
        for (int r = 3; r < 16; r++) begin
            if (r >= 7 && r <= 11) continue;
            step(2'b10, 4'(r), 7'h00, "R8 select reserved");
            step(2'b00, 4'd0, 7'h7f, "R8 reserved holds");
            step(2'b00, 4'd0, 7'h7f, "R8 reserved holds");
        end
        check("R8 total", 8'd1);

        // R6/R9: cycle counting across wrap
        step(2'b01, 4'd0, 7'h00, "R4 clear");
        step(2'b10, 4'd0, 7'h00, "R6 select cycles");
        for (int i = 0; i < 255; i++) step(2'b00, 4'd0, 7'h00, "R6 cycles");
        check("R6 full", 8'd255);
        step(2'b00, 4'd0, 7'h00, "R9 wrap");
        check("R9 wrap to zero", 8'd0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int   pick;
            logic [1:0] op;
            pick = $urandom_range(0, 19);
            op = (pick < 14) ? 2'b00 : (pick < 16) ? 2'b10 : (pick < 18) ? 2'b11 : 2'b01;
            step(op, 4'($urandom_range(0, 15)), 7'($urandom), "R3 random");
        end

        // R1: reset in the middle
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_run = 1'b0; m_sel = 4'd0; m_cnt = '0;
        check("R1 mid reset", '0);
        step(2'b00, 4'd0, 7'h7f, "R1 idle after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule